// File: doc/BRIEF.md
# Chip-Select Framed Serial Register Endpoint

This block is the target side of a four-wire serial link that exposes a small register file to an external master. The serial clock, select and data-in pins are brought into the much faster system clock through two-flop synchronisers. All edge decisions are then made from the synchronised copies. Each assertion of the active-low select opens one frame. The first word of the frame is a command: its most significant bit chooses read (1) or write (0), and its low bits pick one of the registers. The word after it is either the value to store or the value returned.

The select line is the hard frame boundary. Releasing it clears the bit counter, so every frame starts at bit 0. A write is committed only at that release, and only if the frame held exactly one command word and one data word. A short, over-long or glitched frame leaves every register untouched. The return line is driven only while the block is selected, so several targets can share it.

Clock polarity, clock phase and bit order are configuration inputs. They are held steady while a frame is in progress.

Top module: `spi_reg_endpoint`

## Requirements
- R1: `spi_miso_oe` is 0 after reset. It becomes 1 within 4 system clocks of the select going low. It returns to 0 within 4 system clocks of the select going high.
- R2: Raising the select clears the bit counter, so a frame that was abandoned part way has no effect on how the next frame is decoded.
- R3: A write command stores its data word only when the select is raised after exactly 2×WORD_W bits. A frame with more bits than that changes no register.
- R4: While the command word is being shifted in, the return line carries zeros.
- R5: Data-in is sampled on the leading clock edge when `cfg_cpha`=0 and on the trailing edge when it is 1. The leading edge is the first edge away from the idle level `cfg_cpol`. The return line changes on the other edge, so all four mode combinations transfer data correctly.
- R6: With `cfg_lsb_first`=0, words travel most significant bit first; with 1, least significant bit first. A register keeps the same value whichever order was used to write it.
- R7: A write frame whose select rises before 2×WORD_W bits have arrived is discarded, and no register changes.
- R8: A read command returns the addressed register during the word that follows the command, in the configured bit order. Data-in bits received during that word do not modify any register.
- R9: In the command word, bit WORD_W-1 is the read flag, and bits [3:0] select one of 16 independent registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| cfg_lsb_first | input | 1 | 1: least significant bit first on the wire |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low select / frame boundary |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Output enable for the return line |

## Verification
The assertions rely on three conditions at the inputs:
- The configuration inputs stay constant while the select is low.
- Each serial clock level lasts at least six system clocks, so the synchronised copy reports every edge once.
- Data-in settles one half period before its sampling edge.

The bench master drives the pins on the falling system clock. It holds each serial clock level for eight system clocks, and it changes the mode or bit order only between frames with the select high. Deliberately broken frames are still built from the same legal edges; only their bit count or select timing is wrong.

// File: rtl/spi_ep_pkg.sv
package spi_ep_pkg;

  // Returns 1 when data is sampled on the rising serial clock edge.
  // Leading edge is away from idle; phase 0 samples on the leading edge.
  function automatic logic sample_on_rise(input logic cpol, input logic cpha);
    return ~(cpol ^ cpha);
  endfunction

endpackage

// File: rtl/spi_ep_sync.sv
module spi_ep_sync #(
  parameter int              WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/spi_ep_edge.sv
module spi_ep_edge
  import spi_ep_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sclk_s,
  input  logic cs_n_s,
  input  logic cpol,
  input  logic cpha,
  output logic sample_p,
  output logic shift_p,
  output logic cs_rise
);
  logic sclk_d;
  logic cs_d;
  logic rise;
  logic fall;
  logic on_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_n_s;
    end
  end

  always_comb begin
    on_rise  = sample_on_rise(cpol, cpha);
    rise     = sclk_s & ~sclk_d & ~cs_n_s;
    fall     = ~sclk_s & sclk_d & ~cs_n_s;
    sample_p = on_rise ? rise : fall;
    shift_p  = on_rise ? fall : rise;
    cs_rise  = cs_n_s & ~cs_d;
  end
endmodule

// File: rtl/spi_ep_frame.sv
module spi_ep_frame #(
  parameter int WORD_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_s,
  input  logic              cs_rise,
  input  logic              sample_p,
  input  logic              shift_p,
  input  logic              mosi_s,
  input  logic              lsb_first,
  input  logic [WORD_W-1:0] rd_data,
  output logic              miso_q,
  output logic              miso_oe_q,
  output logic [IDX_W-1:0]  cmd_idx,
  output logic              wr_en,
  output logic [WORD_W-1:0] wr_data
);
  localparam int CNT_W = $clog2(2*WORD_W + 2);
  localparam int BIT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] CMD_END   = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] FRAME_END = CNT_W'(2*WORD_W);
  localparam logic [CNT_W-1:0] CNT_SAT   = CNT_W'(2*WORD_W + 1);
  localparam logic [BIT_W-1:0] TOP_BIT   = BIT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] sr;
  logic [WORD_W-1:0] sr_next;
  logic              cmd_rd;
  logic              in_data;
  logic [BIT_W-1:0]  kpos;
  logic [BIT_W-1:0]  pos;
  logic              out_bit;

  always_comb begin
    if (lsb_first) sr_next = {mosi_s, sr[WORD_W-1:1]};
    else           sr_next = {sr[WORD_W-2:0], mosi_s};
  end

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else if (sample_p) sr <= sr_next;
  end

  // Bit counter: cleared whenever the select is high (frame boundary)
  always_ff @(posedge clk) begin
    if (rst || cs_n_s) cnt <= '0;
    else if (sample_p && cnt != CNT_SAT) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_rd  <= 1'b0;
      cmd_idx <= '0;
    end else if (sample_p && cnt == CMD_END - 1'b1) begin
      cmd_rd  <= sr_next[WORD_W-1];
      cmd_idx <= sr_next[IDX_W-1:0];
    end
  end

  // Commit only on release, only for an exact command+data frame
  always_ff @(posedge clk) begin
    if (rst) wr_en <= 1'b0;
    else     wr_en <= cs_rise && (cnt == FRAME_END) && !cmd_rd;
  end
  assign wr_data = sr;

  always_comb begin
    in_data = (cnt >= CMD_END) && (cnt < FRAME_END) && cmd_rd;
    kpos    = BIT_W'(cnt - CMD_END);
    pos     = lsb_first ? kpos : (TOP_BIT - kpos);
    out_bit = in_data ? rd_data[pos] : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      miso_q    <= 1'b0;
      miso_oe_q <= 1'b0;
    end else begin
      miso_oe_q <= !cs_n_s;
      if (cs_n_s)       miso_q <= 1'b0;
      else if (shift_p) miso_q <= out_bit;
    end
  end

  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> !miso_oe_q); // R1
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> (cnt == '0)); // R2
  AST_COMMIT_FULL: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ($past(cnt) == FRAME_END)); // R3
  AST_PLACEHOLDER: assert property (@(posedge clk) disable iff (rst)
    (!cs_n_s && cnt < CMD_END) |-> !miso_q); // R4
  AST_CNT_ON_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    (!cs_n_s && !sample_p) |=> $stable(cnt)); // R5
endmodule

// File: rtl/spi_ep_regfile.sv
module spi_ep_regfile #(
  parameter int WORD_W = 8,
  parameter int DEPTH  = 16,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/spi_reg_endpoint.sv
module spi_reg_endpoint #(
  parameter int WORD_W    = 8,
  parameter int REG_COUNT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic cfg_cpol,
  input  logic cfg_cpha,
  input  logic cfg_lsb_first,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_oe
);
  localparam int IDX_W = $clog2(REG_COUNT);

  logic              sclk_s, cs_n_s, mosi_s;
  logic              sample_p, shift_p, cs_rise;
  logic [IDX_W-1:0]  cmd_idx;
  logic              wr_en;
  logic [WORD_W-1:0] wr_data;
  logic [WORD_W-1:0] rd_data;

  spi_ep_sync #(.WIDTH(3), .RST_VAL(3'b010)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({spi_sclk, spi_cs_n, spi_mosi}),
    .q   ({sclk_s, cs_n_s, mosi_s})
  );

  spi_ep_edge u_edge (
    .clk      (clk),
    .rst      (rst),
    .sclk_s   (sclk_s),
    .cs_n_s   (cs_n_s),
    .cpol     (cfg_cpol),
    .cpha     (cfg_cpha),
    .sample_p (sample_p),
    .shift_p  (shift_p),
    .cs_rise  (cs_rise)
  );

  spi_ep_frame #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .cs_n_s    (cs_n_s),
    .cs_rise   (cs_rise),
    .sample_p  (sample_p),
    .shift_p   (shift_p),
    .mosi_s    (mosi_s),
    .lsb_first (cfg_lsb_first),
    .rd_data   (rd_data),
    .miso_q    (spi_miso),
    .miso_oe_q (spi_miso_oe),
    .cmd_idx   (cmd_idx),
    .wr_en     (wr_en),
    .wr_data   (wr_data)
  );

  spi_ep_regfile #(.WORD_W(WORD_W), .DEPTH(REG_COUNT), .AW(IDX_W)) u_regs (
    .clk   (clk),
    .we    (wr_en),
    .addr  (cmd_idx),
    .wdata (wr_data),
    .rdata (rd_data)
  );
endmodule

// File: tb/spi_reg_endpoint_tb.sv
module spi_reg_endpoint_tb;
  localparam int W    = 8;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso, spi_miso_oe;
  int   n_chk = 0;
  int   n_fail = 0;

  always #5 clk = ~clk;

  spi_reg_endpoint u_dut (
    .clk (clk), .rst (rst),
    .cfg_cpol (cfg_cpol), .cfg_cpha (cfg_cpha), .cfg_lsb_first (cfg_lsb_first),
    .spi_sclk (spi_sclk), .spi_cs_n (spi_cs_n), .spi_mosi (spi_mosi),
    .spi_miso (spi_miso), .spi_miso_oe (spi_miso_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // bits[i] is the i-th bit on the wire
  function automatic logic [31:0] pack_frame(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [31:0] r = '0;
    for (int i = 0; i < W; i++) begin
      r[i]     = cfg_lsb_first ? a[i] : a[W-1-i];
      r[W + i] = cfg_lsb_first ? b[i] : b[W-1-i];
    end
    return r;
  endfunction

  function automatic logic [W-1:0] unpack_word(input logic [31:0] rx, input int base);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      if (cfg_lsb_first) r[i] = rx[base + i];
      else               r[W-1-i] = rx[base + i];
    end
    return r;
  endfunction

  task automatic spi_frame(input logic [31:0] bits, input int n, output logic [31:0] rx,
                           output logic oe_mid);
    rx = '0;
    spi_sclk = cfg_cpol;
    spi_cs_n = 1'b0;
    wait_clk(HALF);
    oe_mid = spi_miso_oe;
    for (int i = 0; i < n; i++) begin
      if (!cfg_cpha) begin
        spi_mosi = bits[i];
        wait_clk(HALF);
        rx[i] = spi_miso;
        spi_sclk = ~cfg_cpol;
        wait_clk(HALF);
        spi_sclk = cfg_cpol;
      end else begin
        spi_sclk = ~cfg_cpol;
        spi_mosi = bits[i];
        wait_clk(HALF);
        rx[i] = spi_miso;
        spi_sclk = cfg_cpol;
        wait_clk(HALF);
      end
    end
    wait_clk(HALF);
    spi_cs_n = 1'b1;
    wait_clk(4);
    chk("R1 oe low after release", {31'd0, spi_miso_oe}, 32'd0);
    wait_clk(10);
  endtask

  task automatic reg_write(input logic [3:0] idx, input logic [W-1:0] val, input int n);
    logic [31:0] rx;
    logic oe;
    spi_frame(pack_frame({1'b0, 3'b000, idx}, val), n, rx, oe);
  endtask

  task automatic reg_read(input logic [3:0] idx, input logic [W-1:0] mosi_fill,
                          output logic [W-1:0] val, output logic [W-1:0] cmd_phase,
                          output logic oe);
    logic [31:0] rx;
    spi_frame(pack_frame({1'b1, 3'b000, idx}, mosi_fill), 2*W, rx, oe);
    val = unpack_word(rx, W);
    cmd_phase = rx[W-1:0];
  endtask

  task automatic t_reset();
    chk("R1 reset oe", {31'd0, spi_miso_oe}, 32'd0);
    chk("R4 reset miso", {31'd0, spi_miso}, 32'd0);
  endtask

  task automatic t_modes();
    logic [W-1:0] v, c;
    logic oe;
    for (int m = 0; m < 4; m++) begin
      cfg_cpol = m[1];
      cfg_cpha = m[0];
      wait_clk(4);
      reg_write(4'(m + 1), 8'hA5 ^ 8'(m * 37), 2*W);
      reg_read(4'(m + 1), 8'h00, v, c, oe);
      chk("R5 mode readback", {24'd0, v}, {24'd0, 8'hA5 ^ 8'(m * 37)});
      chk("R4 command phase zeros", {24'd0, c}, 32'd0);
      chk("R1 oe while selected", {31'd0, oe}, 32'd1);
    end
    cfg_cpol = 1'b0;
    cfg_cpha = 1'b0;
  endtask

  task automatic t_bit_order();
    logic [W-1:0] v, c;
    logic oe;
    cfg_lsb_first = 1'b1;
    wait_clk(4);
    reg_write(4'd6, 8'h1D, 2*W);
    reg_read(4'd6, 8'h00, v, c, oe);
    chk("R6 lsb-first readback", {24'd0, v}, 32'h1D);
    cfg_lsb_first = 1'b0;
    wait_clk(4);
    reg_read(4'd6, 8'h00, v, c, oe);
    chk("R6 msb-first read of lsb-written", {24'd0, v}, 32'h1D);
  endtask

  task automatic t_short_long();
    logic [W-1:0] v, c;
    logic oe;
    reg_write(4'd2, 8'h5A, 2*W);
    reg_write(4'd2, 8'hFF, 2*W - 3);
    reg_read(4'd2, 8'h00, v, c, oe);
    chk("R7 short frame discarded", {24'd0, v}, 32'h5A);
    reg_write(4'd2, 8'h33, 2*W + 3);
    reg_read(4'd2, 8'h00, v, c, oe);
    chk("R3 long frame discarded", {24'd0, v}, 32'h5A);
  endtask

  task automatic t_glitch();
    logic [W-1:0] v, c;
    logic oe;
    logic [31:0] rx;
    spi_frame(32'hFFFF_FFFF, 5, rx, oe);
    reg_write(4'd9, 8'h96, 2*W);
    reg_read(4'd9, 8'h00, v, c, oe);
    chk("R2 frame after abort", {24'd0, v}, 32'h96);
  endtask

  task automatic t_read_no_write();
    logic [W-1:0] v, c;
    logic oe;
    reg_write(4'd11, 8'h42, 2*W);
    reg_read(4'd11, 8'hFF, v, c, oe);
    chk("R8 read value", {24'd0, v}, 32'h42);
    reg_read(4'd11, 8'h00, v, c, oe);
    chk("R8 read frame did not write", {24'd0, v}, 32'h42);
  endtask

  task automatic t_all_regs();
    logic [W-1:0] v, c;
    logic oe;
    for (int i = 0; i < 16; i++) reg_write(4'(i), 8'(i * 17) ^ 8'h3C, 2*W);
    for (int i = 0; i < 16; i++) begin
      reg_read(4'(i), 8'h00, v, c, oe);
      chk("R9 register index decode", {24'd0, v}, {24'd0, 8'(i * 17) ^ 8'h3C});
    end
  endtask

  initial begin
    fork
      begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(5);
        t_reset();
        t_modes();
        t_bit_order();
        t_short_long();
        t_glitch();
        t_read_no_write();
        t_all_regs();
      end
      begin
        wait_clk(200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule